// File: doc/BRIEF.md
# Masked Compare Conditional Jump Unit

This unit carries out one two-word conditional branch for a small script sequencer. The first word holds the branch controls: an expected bus phase, a polarity bit, a wait flag, an 8-bit compare mask and an 8-bit compare value. The second word holds a 32-bit branch target. The unit compares the current bus phase with the expected phase. It also compares the captured first-received data byte with the value, skipping every bit whose mask bit is set. The branch condition holds only when both compares match. The polarity bit then decides whether a true condition or a false condition takes the branch.

If the wait flag is set, the compare does not happen until a bus phase arrives that no earlier compare has used. A phase becomes available when the phase strobe pulses. Any compare uses up that availability. When the branch is taken, the unit issues a one-cycle fetch request for the target and loads the target plus 4 as the next instruction pointer. When it is not taken, the pointer moves past the two-word instruction. The sequencer starts an instruction while `ready` is high. It gets the result with a one-cycle `done` pulse.

Top module: `cj_unit`

## Requirements
- R1: After reset, `ready` is 1 and `done`, `jump_taken`, `fetch_req`, `next_ip` and `fetch_addr` are all 0.
- R2: The data compare matches when `((first_byte ^ w0[7:0]) & ~w0[15:8]) == 0`. A set bit in the mask field `w0[15:8]` excludes that bit. For example, mask 0x7F with value 0x80 tests only bit 7.
- R3: The phase compare matches when `phase_cur == w0[26:24]`. The condition is true only when both the phase compare and the data compare match.
- R4: With `w0[19]` = 1 the branch is taken when the condition is true. With `w0[19]` = 0 it is taken when the condition is false.
- R5: When the branch is taken, `jump_taken` = 1 and `next_ip` = `instr_w1 + 4`. `fetch_req` pulses together with `done`, and `fetch_addr` = `instr_w1`.
- R6: When the branch is not taken, `jump_taken` = 0, `next_ip` = `instr_addr + 8` and `fetch_req` stays 0.
- R7: With `w0[16]` = 0 the compare uses the inputs present in the cycle after `start` is accepted. `done` is high for exactly that next cycle.
- R8: With `w0[16]` = 1 the compare is held while no unserviced phase exists. An unserviced phase is a `phase_strobe` seen since the last compare, or one seen in the current cycle. `done` stays 0 while the compare is held.
- R9: Every compare, with or without the wait flag, marks the phase as serviced. This includes a strobe that arrives in the compare cycle itself. A later wait-mode instruction therefore blocks until a new strobe arrives.
- R10: `start` is accepted only while `ready` is 1. `ready` falls in the cycle after acceptance and rises again with `done`. A `start` given while `ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a branch instruction |
| instr_addr | input | 32 | Address of the first word of the instruction |
| instr_w0 | input | 32 | First word: phase, polarity, wait, mask, value |
| instr_w1 | input | 32 | Second word: branch target |
| phase_strobe | input | 1 | A new bus phase is reported |
| phase_cur | input | 3 | Current bus phase |
| first_byte | input | 8 | Captured first-received data byte |
| ready | output | 1 | Unit can accept `start` |
| done | output | 1 | One-cycle completion pulse |
| jump_taken | output | 1 | Result of the last instruction |
| next_ip | output | 32 | New instruction pointer |
| fetch_req | output | 1 | Fetch request for the branch target |
| fetch_addr | output | 32 | Address to fetch |

## Verification
Two events can land in the same cycle: a fresh phase strobe, and the compare that uses up the serviced flag. The bench causes this overlap in two ways. It sends the strobe in the evaluation cycle of an immediate-mode instruction, and it sends the strobe as the releasing event of a blocked wait-mode instruction. In both cases it judges the outcome by running a later wait-mode instruction, which must block until a newer strobe appears. A phase strobe sent while the unit is idle must instead let the next wait-mode compare go ahead without any further strobe.

// File: rtl/cj_pkg.sv
package cj_pkg;
    parameter int CJ_WORD_W  = 32;
    parameter int CJ_DATA_W  = 8;
    parameter int CJ_PHASE_W = 3;

    localparam int CJ_VAL_LSB   = 0;
    localparam int CJ_MASK_LSB  = CJ_VAL_LSB + CJ_DATA_W;
    localparam int CJ_WAIT_BIT  = 16;
    localparam int CJ_POL_BIT   = 19;
    localparam int CJ_PHASE_LSB = 24;

    typedef struct packed {
        logic [CJ_PHASE_W-1:0] want_phase;
        logic                  on_true;
        logic                  hold_phase;
        logic [CJ_DATA_W-1:0]  mask;
        logic [CJ_DATA_W-1:0]  value;
    } cj_ctrl_t;

    typedef enum logic {
        CJ_IDLE = 1'b0,
        CJ_EVAL = 1'b1
    } cj_state_e;
endpackage

// File: rtl/cj_decode.sv
module cj_decode
    import cj_pkg::*;
(
    input  logic [CJ_WORD_W-1:0] word0,
    output cj_ctrl_t             ctrl
);
    always_comb begin
        ctrl.value      = word0[CJ_VAL_LSB  +: CJ_DATA_W];
        ctrl.mask       = word0[CJ_MASK_LSB +: CJ_DATA_W];
        ctrl.hold_phase = word0[CJ_WAIT_BIT];
        ctrl.on_true    = word0[CJ_POL_BIT];
        ctrl.want_phase = word0[CJ_PHASE_LSB +: CJ_PHASE_W];
    end
endmodule

// File: rtl/cj_match.sv
module cj_match
    import cj_pkg::*;
(
    input  cj_ctrl_t              ctrl,
    input  logic [CJ_DATA_W-1:0]  byte_in,
    input  logic [CJ_PHASE_W-1:0] phase_in,
    output logic                  data_hit,
    output logic                  phase_hit,
    output logic                  cond
);
    logic [CJ_DATA_W-1:0] bit_ok;

    // one lane per data bit: a set mask bit forces that lane to agree
    for (genvar i = 0; i < CJ_DATA_W; i++) begin : g_lane
        assign bit_ok[i] = ctrl.mask[i] | ~(byte_in[i] ^ ctrl.value[i]);
    end

    assign data_hit  = &bit_ok;
    assign phase_hit = (phase_in == ctrl.want_phase);
    assign cond      = data_hit & phase_hit;
endmodule

// File: rtl/cj_phase_track.sv
module cj_phase_track (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic consume,
    output logic avail
);
    logic fresh_d, fresh_q;

    assign avail = fresh_q | strobe;

    always_comb begin
        fresh_d = avail & ~consume;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fresh_q <= 1'b0;
        else        fresh_q <= fresh_d;
    end
endmodule

// File: rtl/cj_unit.sv
module cj_unit
    import cj_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     instr_addr,
    input  logic [CJ_WORD_W-1:0]  instr_w0,
    input  logic [ADDR_W-1:0]     instr_w1,
    input  logic                  phase_strobe,
    input  logic [CJ_PHASE_W-1:0] phase_cur,
    input  logic [CJ_DATA_W-1:0]  first_byte,
    output logic                  ready,
    output logic                  done,
    output logic                  jump_taken,
    output logic [ADDR_W-1:0]     next_ip,
    output logic                  fetch_req,
    output logic [ADDR_W-1:0]     fetch_addr
);
    localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] STEP_TWO = ADDR_W'(2 * WORD_BYTES);

    typedef struct packed {
        cj_state_e         state;
        cj_ctrl_t          ctrl;
        logic [ADDR_W-1:0] target;
        logic [ADDR_W-1:0] base;
        logic              done;
        logic              taken;
        logic [ADDR_W-1:0] next_ip;
        logic              fetch_req;
        logic [ADDR_W-1:0] fetch_addr;
    } regs_t;

    regs_t    r_d, r_q;
    cj_ctrl_t dec_ctrl;
    logic     data_hit, phase_hit, cond;
    logic     avail, consume, go, take;

    cj_decode u_dec (
        .word0 (instr_w0),
        .ctrl  (dec_ctrl)
    );

    cj_match u_match (
        .ctrl      (r_q.ctrl),
        .byte_in   (first_byte),
        .phase_in  (phase_cur),
        .data_hit  (data_hit),
        .phase_hit (phase_hit),
        .cond      (cond)
    );

    cj_phase_track u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (phase_strobe),
        .consume (consume),
        .avail   (avail)
    );

    always_comb begin
        r_d           = r_q;
        r_d.done      = 1'b0;
        r_d.fetch_req = 1'b0;
        go            = ~r_q.ctrl.hold_phase | avail;
        take          = (cond == r_q.ctrl.on_true);
        consume       = 1'b0;
        unique case (r_q.state)
            CJ_IDLE: begin
                if (start) begin
                    r_d.ctrl   = dec_ctrl;
                    r_d.target = instr_w1;
                    r_d.base   = instr_addr;
                    r_d.state  = CJ_EVAL;
                end
            end
            CJ_EVAL: begin
                if (go) begin
                    consume   = 1'b1;
                    r_d.done  = 1'b1;
                    r_d.taken = take;
                    r_d.state = CJ_IDLE;
                    if (take) begin
                        r_d.next_ip    = r_q.target + STEP_ONE;
                        r_d.fetch_req  = 1'b1;
                        r_d.fetch_addr = r_q.target;
                    end else begin
                        r_d.next_ip = r_q.base + STEP_TWO;
                    end
                end
            end
            default: r_d.state = CJ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ready      = (r_q.state == CJ_IDLE);
    assign done       = r_q.done;
    assign jump_taken = r_q.taken;
    assign next_ip    = r_q.next_ip;
    assign fetch_req  = r_q.fetch_req;
    assign fetch_addr = r_q.fetch_addr;
endmodule

// File: rtl/cj_unit_chk.sv
module cj_unit_chk #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ready,
    input logic              done,
    input logic              jump_taken,
    input logic [ADDR_W-1:0] next_ip,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr
);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fetch_with_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (done && jump_taken));

    assert_taken_ip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && jump_taken) |-> (next_ip == fetch_addr + ADDR_W'(WORD_BYTES)));

    assert_no_fetch_untaken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !jump_taken) |-> !fetch_req);

    assert_accept_drops_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready);

    assert_ready_returns_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> done);
endmodule

bind cj_unit cj_unit_chk #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ready      (ready),
    .done       (done),
    .jump_taken (jump_taken),
    .next_ip    (next_ip),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr)
);

// File: tb/sim_cj_unit.sv
`timescale 1ns/1ps
module sim_cj_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr_addr = '0;
    logic [31:0] instr_w0 = '0;
    logic [31:0] instr_w1 = '0;
    logic        phase_strobe = 1'b0;
    logic [2:0]  phase_cur = '0;
    logic [7:0]  first_byte = '0;
    logic        ready, done, jump_taken, fetch_req;
    logic [31:0] next_ip, fetch_addr;

    int n_checks = 0;
    int n_fail = 0;
    bit m_fresh = 1'b0;

    always #2.5 clk = ~clk;

    cj_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr_addr(instr_addr),
        .instr_w0(instr_w0), .instr_w1(instr_w1), .phase_strobe(phase_strobe),
        .phase_cur(phase_cur), .first_byte(first_byte), .ready(ready), .done(done),
        .jump_taken(jump_taken), .next_ip(next_ip), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr)
    );

    function automatic logic [31:0] mk_w0(input logic [2:0] ph, input bit pol,
                                          input bit hold, input logic [7:0] mask,
                                          input logic [7:0] val);
        return {5'b0, ph, 4'b0, pol, 2'b0, hold, mask, val};
    endfunction

    function automatic bit exp_take(input logic [31:0] w0, input logic [7:0] b,
                                    input logic [2:0] ph);
        bit c;
        c = (ph == w0[26:24]) && (((b ^ w0[7:0]) & ~w0[15:8]) == 8'h00);
        return c == w0[19];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pre_strobe(input logic [2:0] ph);
        phase_cur = ph;
        phase_strobe = 1'b1;
        @(negedge clk);
        phase_strobe = 1'b0;
        m_fresh = 1'b1;
    endtask

    // start an instruction, hold it n_block cycles if it must wait, then finish
    task automatic run(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] addr,
                       input logic [7:0] b, input logic [2:0] ph, input int n_block,
                       input bit strobe_end, input string tag);
        bit tk;
        start = 1'b1; instr_w0 = w0; instr_w1 = w1; instr_addr = addr;
        @(negedge clk);
        start = 1'b0;
        chk("R10 ready low after accept", ready, 0);
        first_byte = b; phase_cur = ph;
        if (w0[16] && !m_fresh) begin
            for (int i = 0; i < n_block; i++) begin
                @(negedge clk);
                chk({tag, " held without fresh phase"}, done, 0);
            end
            strobe_end = 1'b1;
        end
        phase_strobe = strobe_end;
        @(negedge clk);
        phase_strobe = 1'b0;
        m_fresh = 1'b0;
        tk = exp_take(w0, b, ph);
        chk("R7 done pulse", done, 1);
        chk("R10 ready with done", ready, 1);
        chk("R2/R3/R4 jump_taken", jump_taken, tk);
        chk(tk ? "R5 next_ip" : "R6 next_ip", next_ip, tk ? w1 + 32'd4 : addr + 32'd8);
        chk(tk ? "R5 fetch_req" : "R6 fetch_req", fetch_req, tk);
        if (tk) chk("R5 fetch_addr", fetch_addr, w1);
        @(negedge clk);
        chk("R7 done one cycle", done, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", ready, 1);
        chk("R1 done", done, 0);
        chk("R1 jump_taken", jump_taken, 0);
        chk("R1 fetch_req", fetch_req, 0);
        chk("R1 next_ip", next_ip, 0);
        chk("R1 fetch_addr", fetch_addr, 0);

        // R2: mask 0x7F, value 0x80 tests only bit 7
        run(mk_w0(3'd2, 1, 0, 8'h7F, 8'h80), 32'h0000_1000, 32'h0000_0200, 8'hC3, 3'd2, 0, 0, "R2");
        run(mk_w0(3'd2, 1, 0, 8'h7F, 8'h80), 32'h0000_1000, 32'h0000_0200, 8'h41, 3'd2, 0, 0, "R2");
        // R3: phase mismatch with matching data
        run(mk_w0(3'd5, 1, 0, 8'h00, 8'hA5), 32'h0000_2000, 32'h0000_0300, 8'hA5, 3'd4, 0, 0, "R3");
        // R4: jump on false
        run(mk_w0(3'd5, 0, 0, 8'h00, 8'hA5), 32'h0000_2000, 32'h0000_0300, 8'hA5, 3'd4, 0, 0, "R4");
        run(mk_w0(3'd5, 0, 0, 8'h00, 8'hA5), 32'h0000_2000, 32'h0000_0300, 8'hA5, 3'd5, 0, 0, "R4");
        // R8: wait mode blocks without a fresh phase, then a strobe releases it
        run(mk_w0(3'd1, 1, 1, 8'hF0, 8'h0C), 32'h0000_3000, 32'h0000_0400, 8'h5C, 3'd1, 4, 1, "R8");
        // R8: strobe while idle lets the wait go through at once
        pre_strobe(3'd3);
        run(mk_w0(3'd3, 1, 1, 8'h00, 8'h11), 32'h0000_4000, 32'h0000_0500, 8'h11, 3'd3, 0, 0, "R8");
        // R9: strobe in the compare cycle of an immediate instruction is consumed
        run(mk_w0(3'd0, 1, 0, 8'hFF, 8'h00), 32'h0000_5000, 32'h0000_0600, 8'h99, 3'd0, 0, 1, "R9");
        run(mk_w0(3'd0, 1, 1, 8'hFF, 8'h00), 32'h0000_5000, 32'h0000_0600, 8'h99, 3'd6, 3, 1, "R9");
        // R9: the releasing strobe of the previous wait is also consumed
        run(mk_w0(3'd6, 0, 1, 8'h0F, 8'h30), 32'h0000_6000, 32'h0000_0700, 8'h3F, 3'd6, 2, 1, "R9");

        // R10: start while busy is ignored
        start = 1'b1; instr_w0 = mk_w0(3'd2, 1, 1, 8'h00, 8'h42);
        instr_w1 = 32'h0000_7000; instr_addr = 32'h0000_0800;
        @(negedge clk);
        first_byte = 8'h42; phase_cur = 3'd2;
        instr_w0 = mk_w0(3'd7, 0, 0, 8'h00, 8'h00); instr_w1 = 32'h0000_9000;
        instr_addr = 32'h0000_0900;
        @(negedge clk);
        start = 1'b0;
        chk("R10 busy start ignored, no done", done, 0);
        chk("R10 ready low while busy", ready, 0);
        phase_strobe = 1'b1;
        @(negedge clk);
        phase_strobe = 1'b0;
        chk("R10 first instruction done", done, 1);
        chk("R10 first instruction taken", jump_taken, 1);
        chk("R10 first instruction next_ip", next_ip, 32'h0000_7004);
        repeat (3) begin
            @(negedge clk);
            chk("R10 no second done", done, 0);
        end
        m_fresh = 1'b0;

        for (int k = 0; k < 300; k++) begin
            logic [7:0] msk, val, b;
            logic [2:0] ph, want;
            bit hold, pol;
            msk = 8'($urandom); val = 8'($urandom);
            want = 3'($urandom); pol = 1'($urandom); hold = 1'($urandom);
            b = ($urandom % 2) ? (val ^ (8'($urandom) & msk)) : 8'($urandom);
            ph = ($urandom % 2) ? want : 3'($urandom);
            if ($urandom % 4 == 0) pre_strobe(3'($urandom));
            run(mk_w0(want, pol, hold, msk, val), $urandom, $urandom, b, ph,
                int'($urandom % 3), 1'($urandom), "R8");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule